// File: doc/BRIEF.md
# Windowed Frame Buffer Fetch Address Generator

This block feeds a display DMA engine with the 32-bit word addresses it must read to scan a rectangular window out of a larger frame buffer. Software sets a start address, the number of words in each displayed line, the number of lines, a byte skip inserted between lines, and the bit position of the first pixel inside the first word of every line. The generator then emits one address per accepted handshake. Each address is tagged with a last-word-of-line flag and a last-word-of-frame flag. Frames repeat for as long as the run input stays high.

All settings sit behind a double-buffered shadow. Writing the setting inputs does nothing on its own. A one-cycle update pulse arms a transfer. The transfer happens when the current frame ends, or at once if the generator is idle, so no frame ever mixes old and new settings. With window mode off, addresses run linearly and the skip is ignored. The first-pixel position is reported counted from bit 0 for little-endian memory and from bit 31 for big-endian memory.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset `fetch_valid` is 0. All shadow settings are zero, so with no update pulse every frame is a single word at address 0, flagged end-of-line and end-of-frame, with `first_pix_bit` equal to 0.
- R2: Within a line, each accepted address (`fetch_valid` and `fetch_ready` both high) is followed by that address plus 4.
- R3: With window mode on (`cfg_2d_en`=1), the word after the last word of a line is at last address + 4 + `cfg_line_skip`. The skip is an unsigned 16-bit byte count.
- R4: With window mode off, the skip is ignored, so every step is +4. `first_pix_bit` is then 0 for little-endian and 31 for big-endian.
- R5: A line holds `cfg_line_words_m1`+1 words and a frame holds `cfg_lines_m1`+1 lines. `fetch_eol` is 1 exactly on the last word of each line. `fetch_eof` is 1 exactly on the last word of the last line.
- R6: The first address of every frame is the shadowed start address, including the frame that directly follows an end-of-frame word.
- R7: With window mode on and `cfg_big_endian`=0, `first_pix_bit` equals the 5-bit offset, counted upward from bit 0.
- R8: With window mode on and `cfg_big_endian`=1, `first_pix_bit` equals 31 minus the offset, counted downward from bit 31.
- R9: Changing any setting input without an update pulse has no effect on the addresses, flags or bit position.
- R10: An update pulse during a frame leaves the rest of that frame unchanged. The settings present at the frame's end apply from the next frame. A pulse while idle applies at once.
- R11: While `fetch_valid` is 1 and `fetch_ready` is 0, `fetch_valid`, `fetch_addr`, `fetch_eol` and `fetch_eof` hold.
- R12: Lowering `run_en` mid-frame does not cut the frame short. `fetch_valid` drops only after the end-of-frame word has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Keep producing frames while high |
| cfg_base | input | ADDR_W | Frame start byte address (word aligned) |
| cfg_line_words_m1 | input | LEN_W | Words per displayed line minus one |
| cfg_lines_m1 | input | LINES_W | Lines per frame minus one |
| cfg_line_skip | input | INC_W | Extra bytes skipped between lines |
| cfg_pix_offset | input | 5 | First-pixel bit offset in a line's first word |
| cfg_2d_en | input | 1 | Window (two-dimensional) mode enable |
| cfg_big_endian | input | 1 | Memory byte order, 1 = big-endian |
| cfg_update | input | 1 | Arms transfer of setting inputs to the shadow |
| fetch_valid | output | 1 | Address is offered |
| fetch_ready | input | 1 | Consumer accepts the address |
| fetch_addr | output | ADDR_W | Word fetch byte address |
| fetch_eol | output | 1 | Last word of a line |
| fetch_eof | output | 1 | Last word of the frame |
| first_pix_bit | output | 5 | Bit position of the first pixel of each line |

## Verification
The bench sweeps line lengths of one to four words and one to three lines, in both window modes and both byte orders. Every accepted address is compared with an arithmetic model.

Three kinds of fault are targeted:
- A design that drops or double-counts the skip would miss at each line turn.
- A design that reloads the start address one word late would miss at the first word of the next frame.
- A design that mixes up the byte orders would give the wrong first-pixel bit.

Single-word lines and single-line frames are included, because an off-by-one in the end-of-line or end-of-frame compare shows up there first. The bench also pulses update mid-frame, changes settings with no pulse, stalls the consumer, and drops the run input mid-frame. A shadow that loads at once, ignores the pulse, lets the address drift under back-pressure, or stops early would each produce wrong words.

// File: rtl/fb_agen_pkg.sv
package fb_agen_pkg;

   localparam int WORD_BYTES = 4;
   localparam int PIX_OFF_W  = 5;

   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } byte_order_e;

   // Bit index, from bit 0, of the first pixel for a given offset and order.
   function automatic logic [PIX_OFF_W-1:0] pix_bit_index(
      input logic [PIX_OFF_W-1:0] off,
      input byte_order_e          order
   );
      if (order == ORDER_BIG) begin
         pix_bit_index = ~off;
      end else begin
         pix_bit_index = off;
      end
   endfunction

endpackage

// File: rtl/fb_agen_shadow.sv
module fb_agen_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         upd_pulse,
   input  logic         frame_edge,
   input  logic [W-1:0] live_val,
   output logic [W-1:0] held_val,
   output logic [W-1:0] next_val
);

   logic         arm_q;
   logic         take;
   logic [W-1:0] hold_q;

   if (W < 1) begin : g_bad_width
      $error("fb_agen_shadow: W must be at least 1");
   end

   assign take     = frame_edge && (arm_q || upd_pulse);
   assign held_val = hold_q;
   assign next_val = take ? live_val : hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q  <= 1'b0;
         hold_q <= '0;
      end else begin
         if (take) begin
            hold_q <= live_val;
            arm_q  <= 1'b0;
         end else if (upd_pulse) begin
            arm_q  <= 1'b1;
         end
      end
   end

   AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_edge |=> $stable(hold_q)); // R10

   AST_NO_SILENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_pulse && !arm_q) |=> $stable(hold_q)); // R9

endmodule

// File: rtl/fb_agen_pixpos.sv
module fb_agen_pixpos
   import fb_agen_pkg::*;
#(
   parameter bit HAS_BIG_ENDIAN = 1'b1
) (
   input  logic                 win_en,
   input  logic                 big_end,
   input  logic [PIX_OFF_W-1:0] off,
   output logic [PIX_OFF_W-1:0] bit_pos
);

   byte_order_e order;

   if (HAS_BIG_ENDIAN) begin : g_both_orders
      assign order = big_end ? ORDER_BIG : ORDER_LITTLE;
   end else begin : g_little_only
      logic unused_big;
      assign unused_big = big_end;
      assign order = ORDER_LITTLE;
   end

   always_comb begin
      if (win_en) begin
         bit_pos = pix_bit_index(off, order);
      end else begin
         bit_pos = pix_bit_index('0, order);
      end
   end

   always_comb begin
      if (win_en && order == ORDER_LITTLE) begin
         AST_LE_POS: assert (bit_pos == off); // R7
      end
      if (win_en && order == ORDER_BIG) begin
         AST_BE_POS: assert (bit_pos + off == PIX_OFF_W'(31)); // R8
      end
   end

endmodule

// File: rtl/fb_agen_walker.sv
module fb_agen_walker
   import fb_agen_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 8,
   parameter int LINES_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              ready,
   input  logic [ADDR_W-1:0] base_next,
   input  logic [ADDR_W-1:0] base_cur,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [LINES_W-1:0] lines_m1,
   input  logic [ADDR_W-1:0] line_step,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic              eol,
   output logic              eof,
   output logic              frame_edge
);

   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

   logic               valid_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   col_q;
   logic [LINES_W-1:0] row_q;
   logic               fire;

   assign fire       = valid_q && ready;
   assign eol        = (col_q == len_m1);
   assign eof        = eol && (row_q == lines_m1);
   assign frame_edge = !valid_q || (fire && eof);
   assign valid      = valid_q;
   assign addr       = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         col_q   <= '0;
         row_q   <= '0;
      end else if (frame_edge) begin
         valid_q <= run_en;
         addr_q  <= base_next;
         col_q   <= '0;
         row_q   <= '0;
      end else if (fire) begin
         if (eol) begin
            col_q  <= '0;
            row_q  <= row_q + 1'b1;
            addr_q <= addr_q + line_step;
         end else begin
            col_q  <= col_q + 1'b1;
            addr_q <= addr_q + WORD_STEP;
         end
      end
   end

   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready) |=> (valid_q && $stable(addr_q) && $stable(eol) && $stable(eof))); // R11

   AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !eol) |=> (addr_q == $past(addr_q) + WORD_STEP)); // R2

   AST_LINE_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && eol && !eof) |=> (addr_q == $past(addr_q) + $past(line_step))); // R3

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && eof) |=> (addr_q == base_cur)); // R6

   AST_KEEP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !(fire && eof)) |=> valid_q); // R12

endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
   import fb_agen_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int LEN_W          = 8,
   parameter int LINES_W        = 8,
   parameter int INC_W          = 16,
   parameter bit HAS_BIG_ENDIAN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_en,
   input  logic [ADDR_W-1:0]    cfg_base,
   input  logic [LEN_W-1:0]     cfg_line_words_m1,
   input  logic [LINES_W-1:0]   cfg_lines_m1,
   input  logic [INC_W-1:0]     cfg_line_skip,
   input  logic [PIX_OFF_W-1:0] cfg_pix_offset,
   input  logic                 cfg_2d_en,
   input  logic                 cfg_big_endian,
   input  logic                 cfg_update,
   output logic                 fetch_valid,
   input  logic                 fetch_ready,
   output logic [ADDR_W-1:0]    fetch_addr,
   output logic                 fetch_eol,
   output logic                 fetch_eof,
   output logic [PIX_OFF_W-1:0] first_pix_bit
);

   localparam int CFG_W = ADDR_W + LEN_W + LINES_W + INC_W + PIX_OFF_W + 2;
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("fb_addr_gen: ADDR_W out of range");
   end
   if (INC_W > ADDR_W) begin : g_bad_inc
      $error("fb_addr_gen: INC_W wider than ADDR_W");
   end
   if (LEN_W < 1 || LINES_W < 1) begin : g_bad_count
      $error("fb_addr_gen: counter widths must be positive");
   end

   logic [CFG_W-1:0] live_vec, held_vec, next_vec;

   logic [ADDR_W-1:0]    h_base, n_base;
   logic [LEN_W-1:0]     h_len, n_len;
   logic [LINES_W-1:0]   h_lines, n_lines;
   logic [INC_W-1:0]     h_skip, n_skip;
   logic [PIX_OFF_W-1:0] h_off, n_off;
   logic                 h_2d, n_2d, h_big, n_big;

   logic                 frame_edge;
   logic [ADDR_W-1:0]    line_step;

   assign live_vec = {cfg_base, cfg_line_words_m1, cfg_lines_m1, cfg_line_skip,
                      cfg_pix_offset, cfg_2d_en, cfg_big_endian};
   assign {h_base, h_len, h_lines, h_skip, h_off, h_2d, h_big} = held_vec;
   assign {n_base, n_len, n_lines, n_skip, n_off, n_2d, n_big} = next_vec;

   fb_agen_shadow #(
      .W(CFG_W)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_pulse (cfg_update),
      .frame_edge(frame_edge),
      .live_val  (live_vec),
      .held_val  (held_vec),
      .next_val  (next_vec)
   );

   // Only the start address of the next-state view is consumed.
   logic unused_next;
   assign unused_next = ^{n_len, n_lines, n_skip, n_off, n_2d, n_big};

   always_comb begin
      if (h_2d) begin
         line_step = WORD_STEP + ADDR_W'(h_skip);
      end else begin
         line_step = WORD_STEP;
      end
   end

   fb_agen_walker #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .LINES_W(LINES_W)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .ready     (fetch_ready),
      .base_next (n_base),
      .base_cur  (h_base),
      .len_m1    (h_len),
      .lines_m1  (h_lines),
      .line_step (line_step),
      .valid     (fetch_valid),
      .addr      (fetch_addr),
      .eol       (fetch_eol),
      .eof       (fetch_eof),
      .frame_edge(frame_edge)
   );

   fb_agen_pixpos #(
      .HAS_BIG_ENDIAN(HAS_BIG_ENDIAN)
   ) u_pixpos (
      .win_en (h_2d),
      .big_end(h_big),
      .off    (h_off),
      .bit_pos(first_pix_bit)
   );

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> !fetch_valid); // R1

   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready && !fetch_eof && !h_2d) |=> (fetch_addr == $past(fetch_addr) + WORD_STEP)); // R4

   AST_EOF_HAS_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_eof) |-> fetch_eol); // R5

endmodule

// File: tb/fb_addr_gen_tb.sv
module fb_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        run_en;
   logic [31:0] cfg_base;
   logic [7:0]  cfg_line_words_m1;
   logic [7:0]  cfg_lines_m1;
   logic [15:0] cfg_line_skip;
   logic [4:0]  cfg_pix_offset;
   logic        cfg_2d_en;
   logic        cfg_big_endian;
   logic        cfg_update;
   logic        fetch_valid;
   logic        fetch_ready;
   logic [31:0] fetch_addr;
   logic        fetch_eol;
   logic        fetch_eof;
   logic [4:0]  first_pix_bit;

   int vectors = 0;
   int fails   = 0;
   int rdy_cnt = 0;

   always #10 clk = ~clk;

   fb_addr_gen u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .run_en           (run_en),
      .cfg_base         (cfg_base),
      .cfg_line_words_m1(cfg_line_words_m1),
      .cfg_lines_m1     (cfg_lines_m1),
      .cfg_line_skip    (cfg_line_skip),
      .cfg_pix_offset   (cfg_pix_offset),
      .cfg_2d_en        (cfg_2d_en),
      .cfg_big_endian   (cfg_big_endian),
      .cfg_update       (cfg_update),
      .fetch_valid      (fetch_valid),
      .fetch_ready      (fetch_ready),
      .fetch_addr       (fetch_addr),
      .fetch_eol        (fetch_eol),
      .fetch_eof        (fetch_eof),
      .first_pix_bit    (first_pix_bit)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [31:0] b, input int lm1, input int nm1,
                          input int sk, input int of, input bit e2, input bit be);
      cfg_base          = b;
      cfg_line_words_m1 = 8'(lm1);
      cfg_lines_m1      = 8'(nm1);
      cfg_line_skip     = 16'(sk);
      cfg_pix_offset    = 5'(of);
      cfg_2d_en         = e2;
      cfg_big_endian    = be;
   endtask

   // evt_kind: 0 none, 1 alt settings + update pulse, 2 alt settings without pulse, 3 drop run_en
   task automatic collect(input logic [31:0] b, input int lm1, input int nm1,
                          input int sk, input int of, input bit e2, input bit be,
                          input int evt_at, input int evt_kind, input bit stop_after);
      int idx = 0;
      int row = 0;
      int col = 0;
      bit done = 0;
      bit hold_pend = 0;
      logic [31:0] hold_addr = '0;
      logic hold_eol = 0, hold_eof = 0;
      int guard = 0;
      logic [31:0] exp_a;
      int skip_eff;
      while (!done && guard < 400) begin
         guard++;
         @(negedge clk);
         cfg_update  = 1'b0;
         rdy_cnt++;
         fetch_ready = (rdy_cnt % 4) != 2;
         #1;
         if (hold_pend) begin
            chk("R11 valid held", 32'(fetch_valid), 32'd1);
            chk("R11 addr held", fetch_addr, hold_addr);
            chk("R11 flags held", {30'd0, fetch_eol, fetch_eof}, {30'd0, hold_eol, hold_eof});
         end
         hold_pend = fetch_valid && !fetch_ready;
         hold_addr = fetch_addr;
         hold_eol  = fetch_eol;
         hold_eof  = fetch_eof;
         if (fetch_valid && fetch_ready) begin
            skip_eff = e2 ? sk : 0;
            exp_a = b + 32'(4 * (row * (lm1 + 1) + col)) + 32'(row * skip_eff);
            if (idx == 0)                      chk("R6 frame start addr", fetch_addr, exp_a);
            else if (col > 0)                  chk("R2 in-line addr", fetch_addr, exp_a);
            else if (e2)                       chk("R3 line turn addr", fetch_addr, exp_a);
            else                               chk("R4 linear turn addr", fetch_addr, exp_a);
            chk("R5 eol", 32'(fetch_eol), 32'(col == lm1));
            chk("R5 eof", 32'(fetch_eof), 32'(col == lm1 && row == nm1));
            if (!e2)      chk("R4 pix bit", 32'(first_pix_bit), be ? 32'd31 : 32'd0);
            else if (be)  chk("R8 pix bit", 32'(first_pix_bit), 32'(31 - of));
            else          chk("R7 pix bit", 32'(first_pix_bit), 32'(of));
            if (col == lm1 && row == nm1) begin
               done = 1;
               if (stop_after) run_en = 1'b0;
            end else if (col == lm1) begin
               col = 0;
               row++;
            end else begin
               col++;
            end
            idx++;
            if (idx == evt_at) begin
               if (evt_kind == 1 || evt_kind == 2) set_cfg(32'h0000_8000, 1, 1, 64, 9, 1'b1, 1'b0);
               if (evt_kind == 1) cfg_update = 1'b1;
               if (evt_kind == 3) run_en = 1'b0;
            end
         end
      end
      if (!done) chk("R12 frame completes", 32'd0, 32'd1);
   endtask

   task automatic wait_idle();
      int g = 0;
      while (fetch_valid && g < 20) begin
         @(negedge clk);
         #1;
         g++;
      end
   endtask

   task automatic pulse_update();
      @(negedge clk);
      cfg_update = 1'b1;
      @(negedge clk);
      cfg_update = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      run_en      = 1'b0;
      cfg_update  = 1'b0;
      fetch_ready = 1'b0;
      set_cfg(32'h0000_0100, 2, 1, 8, 5, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      #1;
      chk("R1 valid after reset", 32'(fetch_valid), 32'd0);
      rst_n = 1'b1;

      // R1 / R9: settings present but never pulsed -> zero shadow
      @(negedge clk);
      run_en = 1'b1;
      collect(32'd0, 0, 0, 0, 0, 1'b0, 1'b0, -1, 0, 1'b0);
      collect(32'd0, 0, 0, 0, 0, 1'b0, 1'b0, -1, 0, 1'b1);
      wait_idle();
      chk("R12 idle after stop", 32'(fetch_valid), 32'd0);

      // Sweep of small configurations
      for (int lm1 = 0; lm1 < 4; lm1++) begin
         for (int nm1 = 0; nm1 < 3; nm1++) begin
            for (int e2 = 0; e2 < 2; e2++) begin
               for (int be = 0; be < 2; be++) begin
                  int sk = e2 ? (lm1 * 4 + nm1 * 8 + 4) : 12;
                  int of = (lm1 * 7 + nm1 * 3 + be * 11) % 32;
                  logic [31:0] b = 32'h0000_1000 + 32'(lm1 * 'h40 + nm1 * 'h400);
                  set_cfg(b, lm1, nm1, sk, of, e2[0], be[0]);
                  pulse_update();
                  run_en = 1'b1;
                  collect(b, lm1, nm1, sk, of, e2[0], be[0], -1, 0, 1'b1);
                  @(negedge clk);
                  #1;
                  chk("R12 valid low after stopped frame", 32'(fetch_valid), 32'd0);
                  wait_idle();
               end
            end
         end
      end

      // Large skip exercises the full 16-bit field
      set_cfg(32'h0010_0000, 1, 2, 16'hFFFC, 31, 1'b1, 1'b0);
      pulse_update();
      run_en = 1'b1;
      collect(32'h0010_0000, 1, 2, 'hFFFC, 31, 1'b1, 1'b0, -1, 0, 1'b1);
      wait_idle();

      // R10: pulse mid-frame, rest of frame keeps old settings, next frame new
      set_cfg(32'h0000_4000, 2, 2, 20, 3, 1'b1, 1'b1);
      pulse_update();
      run_en = 1'b1;
      collect(32'h0000_4000, 2, 2, 20, 3, 1'b1, 1'b1, 2, 1, 1'b0);
      collect(32'h0000_8000, 1, 1, 64, 9, 1'b1, 1'b0, 1, 2, 1'b0);
      // R9: changed inputs without pulse -> same settings again
      set_cfg(32'h0000_C000, 3, 0, 4, 1, 1'b0, 1'b1);
      collect(32'h0000_8000, 1, 1, 64, 9, 1'b1, 1'b0, 1, 3, 1'b0);
      // R12: run_en dropped after word 1, frame above still completed
      @(negedge clk);
      #1;
      chk("R12 valid low after dropped run", 32'(fetch_valid), 32'd0);

      // R10: pulse while idle applies at once
      set_cfg(32'h0000_2000, 0, 3, 8, 17, 1'b1, 1'b0);
      pulse_update();
      run_en = 1'b1;
      collect(32'h0000_2000, 0, 3, 8, 17, 1'b1, 1'b0, -1, 0, 1'b1);
      wait_idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule